// File: doc/BRIEF.md
# Configurable D/T Logic Cell Register

This block is a single storage element for a programmable logic cell. Its data comes from a sum term, which is the OR of a small set of product-term inputs. One configuration input selects how the element behaves. As a D register it loads the sum term. As a T register it inverts its state when the sum term is 1 and holds it otherwise. Set/reset and J/K behaviour can be built on top of the toggle form.

A second configuration input selects the clock source. In term mode, a rising clock product term triggers the register. In pin mode, the regional clock pin is ANDed with that product term, and the rising edge of the combined signal triggers it. The block runs on one system clock. Both modes are modelled as a single-cycle strobe taken from the sampled trigger signal, so no derived clock is ever built.

The element has its own preset and reset terms. Reset wins over preset, and both win over a clock strobe. A third configuration input selects what goes back to the regional bus for logic expansion: the stored state, or the combinational sum term.

Top module: `lc_flop`

## Requirements
- R1: While rst_ni is low, q_o is 0, and it stays 0 after reset is released until something changes it.
- R2: With cfg_ttype_i = 0 (D type), an effective clock edge loads q_o with the OR of all bits of pterm_i; q_o shows the new value one system clock after the edge is sampled.
- R3: With cfg_ttype_i = 1 (T type), an effective clock edge inverts q_o when the OR of pterm_i is 1 and leaves q_o unchanged when it is 0.
- R4: With cfg_sync_clk_i = 0 (term mode), the effective edge is a 0-to-1 transition of clk_pterm_i between consecutive system clocks, and rclk_i has no effect.
- R5: With cfg_sync_clk_i = 1 (pin mode), the effective edge is a 0-to-1 transition of (rclk_i AND clk_pterm_i); a transition of either signal while the other is 0 does not clock the register.
- R6: In a cycle with no effective edge and no preset or reset term, q_o holds, whatever pterm_i does.
- R7: When arst_i is 1, q_o is 0 on the next system clock, whatever preset, clock or data do.
- R8: When apre_i is 1 and arst_i is 0, q_o is 1 on the next system clock, whatever clock or data do.
- R9: With cfg_fb_d_i = 0, fb_o equals q_o; with cfg_fb_d_i = 1, fb_o equals the OR of pterm_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up clear) |
| cfg_ttype_i | input | 1 | 0: D type, 1: T type |
| cfg_sync_clk_i | input | 1 | 0: clock product term alone, 1: regional pin ANDed with clock term |
| cfg_fb_d_i | input | 1 | 0: feed back state, 1: feed back sum term |
| pterm_i | input | N_TERMS | Product terms of the data sum term |
| clk_pterm_i | input | 1 | Clock product term |
| rclk_i | input | 1 | Regional clock pin |
| apre_i | input | 1 | Preset term |
| arst_i | input | 1 | Reset term |
| q_o | output | 1 | Register state |
| fb_o | output | 1 | Feedback to the regional bus |

## Verification
The assertions check every cycle that reset and preset override the rest with reset winning, that the state holds when there is no strobe, that D and T updates follow the sum term, and that the feedback selector follows its configuration. Only the bench scenarios can show that each clock mode accepts exactly the intended trigger. Those scenarios cover pin toggles that are ignored in term mode and gated rising edges in pin mode. The bench also sweeps every sum-term pattern in both register types, which shows that all product-term inputs take part in the OR.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic {FF_D = 1'b0, FF_T = 1'b1} ff_kind_e;
  typedef enum logic {CLK_TERM = 1'b0, CLK_PIN = 1'b1} clk_mode_e;
  typedef enum logic {FB_Q = 1'b0, FB_D = 1'b1} fb_src_e;
endpackage

// File: rtl/lc_sum_term.sv
module lc_sum_term #(
  parameter int unsigned N_TERMS = 5
) (
  input  logic [N_TERMS-1:0] pterm_i,
  output logic               sum_o
);
  logic [N_TERMS:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_TERMS; g++) begin : g_or
    assign chain[g+1] = chain[g] | pterm_i[g];
  end
  assign sum_o = chain[N_TERMS];
endmodule

// File: rtl/lc_clk_strobe.sv
module lc_clk_strobe
  import lc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic clk_pterm_i,
  input  logic rclk_i,
  output logic strobe_o
);
  clk_mode_e mode;
  logic trig, trig_q;

  assign mode = clk_mode_e'(mode_i);
  // pin mode: regional pin gated by the clock term
  assign trig = (mode == CLK_PIN) ? (rclk_i & clk_pterm_i) : clk_pterm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig;
  end

  assign strobe_o = trig & ~trig_q;
endmodule

// File: rtl/lc_flop_core.sv
module lc_flop_core
  import lc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ttype_i,
  input  logic strobe_i,
  input  logic data_i,
  input  logic apre_i,
  input  logic arst_i,
  output logic q_o
);
  ff_kind_e kind;
  logic q_q, q_d;

  assign kind = ff_kind_e'(ttype_i);

  always_comb begin
    q_d = q_q;
    if (arst_i)        q_d = 1'b0;
    else if (apre_i)   q_d = 1'b1;
    else if (strobe_i) q_d = (kind == FF_T) ? (q_q ^ data_i) : data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/lc_flop.sv
module lc_flop
  import lc_pkg::*;
#(
  parameter int unsigned N_TERMS = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_ttype_i,
  input  logic               cfg_sync_clk_i,
  input  logic               cfg_fb_d_i,
  input  logic [N_TERMS-1:0] pterm_i,
  input  logic               clk_pterm_i,
  input  logic               rclk_i,
  input  logic               apre_i,
  input  logic               arst_i,
  output logic               q_o,
  output logic               fb_o
);
  logic sum, strobe, q;
  fb_src_e fb_src;

  lc_sum_term #(.N_TERMS(N_TERMS)) u_sum (
    .pterm_i(pterm_i),
    .sum_o  (sum)
  );

  lc_clk_strobe u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (cfg_sync_clk_i),
    .clk_pterm_i(clk_pterm_i),
    .rclk_i     (rclk_i),
    .strobe_o   (strobe)
  );

  lc_flop_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ttype_i (cfg_ttype_i),
    .strobe_i(strobe),
    .data_i  (sum),
    .apre_i  (apre_i),
    .arst_i  (arst_i),
    .q_o     (q)
  );

  assign fb_src = fb_src_e'(cfg_fb_d_i);
  assign fb_o   = (fb_src == FB_D) ? sum : q;
  assign q_o    = q;
endmodule

// File: rtl/lc_flop_chk.sv
module lc_flop_chk #(
  parameter int unsigned N_TERMS = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_ttype_i,
  input logic               cfg_sync_clk_i,
  input logic               cfg_fb_d_i,
  input logic [N_TERMS-1:0] pterm_i,
  input logic               clk_pterm_i,
  input logic               rclk_i,
  input logic               apre_i,
  input logic               arst_i,
  input logic               q_o,
  input logic               fb_o
);
  logic prev_trig, cur_trig, edge_seen, any_term;
  assign cur_trig  = cfg_sync_clk_i ? (clk_pterm_i & rclk_i) : clk_pterm_i;
  assign edge_seen = cur_trig && !prev_trig;
  assign any_term  = (pterm_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_trig <= 1'b0;
    else         prev_trig <= cur_trig;
  end

  // R7
  reset_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arst_i |=> !q_o);
  // R8
  preset_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apre_i && !arst_i) |=> q_o);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_seen && !apre_i && !arst_i) |=> $stable(q_o));
  // R2
  d_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_seen && !cfg_ttype_i && !apre_i && !arst_i) |=> (q_o == $past(any_term)));
  // R3
  t_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_seen && cfg_ttype_i && !apre_i && !arst_i) |=> (q_o == ($past(q_o) ^ $past(any_term))));
  // R9
  fb_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_o == (cfg_fb_d_i ? any_term : q_o));
endmodule

bind lc_flop lc_flop_chk #(.N_TERMS(N_TERMS)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_ttype_i   (cfg_ttype_i),
  .cfg_sync_clk_i(cfg_sync_clk_i),
  .cfg_fb_d_i    (cfg_fb_d_i),
  .pterm_i       (pterm_i),
  .clk_pterm_i   (clk_pterm_i),
  .rclk_i        (rclk_i),
  .apre_i        (apre_i),
  .arst_i        (arst_i),
  .q_o           (q_o),
  .fb_o          (fb_o)
);

// File: tb/lc_flop_tb.sv
module lc_flop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_TERMS = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_ttype = 1'b0, cfg_sync = 1'b0, cfg_fb_d = 1'b0;
  logic [N_TERMS-1:0] pterm = '0;
  logic clk_pterm = 1'b0, rclk = 1'b0, apre = 1'b0, arst = 1'b0;
  logic q, fb;
  int errors = 0, checks = 0;
  logic exp_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  lc_flop #(.N_TERMS(N_TERMS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_ttype_i(cfg_ttype), .cfg_sync_clk_i(cfg_sync),
    .cfg_fb_d_i(cfg_fb_d), .pterm_i(pterm), .clk_pterm_i(clk_pterm), .rclk_i(rclk),
    .apre_i(apre), .arst_i(arst), .q_o(q), .fb_o(fb)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_term();
    @(negedge clk); clk_pterm = 1'b1;
    @(negedge clk); clk_pterm = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rclk();
    @(negedge clk); rclk = 1'b1;
    @(negedge clk); rclk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 during reset", q, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 after release", q, 1'b0);

    // R2 D sweep in term mode, with R9 feedback checks
    for (int p = 0; p < 32; p++) begin
      pterm = p[N_TERMS-1:0];
      cfg_fb_d = p[1];
      pulse_term();
      exp_q = (p != 0);
      check("R2 D load", q, exp_q);
      check("R9 feedback", fb, cfg_fb_d ? (p != 0) : exp_q);
    end

    // R3 T sweep
    cfg_ttype = 1'b1; cfg_fb_d = 1'b0;
    for (int p = 0; p < 32; p++) begin
      pterm = p[N_TERMS-1:0];
      pulse_term();
      exp_q = exp_q ^ (p != 0);
      check("R3 T toggle", q, exp_q);
    end

    // R6 no strobe: data changes ignored
    cfg_ttype = 1'b0;
    for (int p = 0; p < 32; p++) begin
      @(negedge clk); pterm = p[N_TERMS-1:0];
    end
    @(negedge clk);
    check("R6 hold", q, exp_q);

    // R4 term mode ignores the regional pin
    pterm = exp_q ? 5'b00000 : 5'b00100;
    pulse_rclk();
    check("R4 pin ignored", q, exp_q);
    pulse_term();
    exp_q = ~exp_q;
    check("R4 term clocks", q, exp_q);

    // R5 pin mode
    cfg_sync = 1'b1;
    pterm = exp_q ? 5'b00000 : 5'b10000;
    rclk = 1'b0;
    pulse_term();
    check("R5 term alone", q, exp_q);
    pulse_rclk();
    check("R5 pin alone", q, exp_q);
    @(negedge clk); rclk = 1'b1; @(negedge clk);
    pulse_term();
    exp_q = ~exp_q;
    check("R5 term with pin high", q, exp_q);
    @(negedge clk); rclk = 1'b0; clk_pterm = 1'b1;
    pterm = exp_q ? 5'b00000 : 5'b00001;
    @(negedge clk);
    pulse_rclk();
    exp_q = ~exp_q;
    check("R5 pin with term high", q, exp_q);
    @(negedge clk); clk_pterm = 1'b0; cfg_sync = 1'b0; @(negedge clk);

    // R7 / R8 priorities, with a simultaneous strobe
    pterm = '0;
    @(negedge clk); apre = 1'b1; clk_pterm = 1'b1;
    @(negedge clk);
    check("R8 preset over strobe", q, 1'b1);
    apre = 1'b0; clk_pterm = 1'b0;
    pterm = 5'b11111;
    @(negedge clk); arst = 1'b1; clk_pterm = 1'b1;
    @(negedge clk);
    check("R7 reset over strobe", q, 1'b0);
    arst = 1'b0; clk_pterm = 1'b0;
    @(negedge clk); apre = 1'b1;
    @(negedge clk);
    check("R8 preset", q, 1'b1);
    arst = 1'b1;
    @(negedge clk);
    check("R7 reset beats preset", q, 1'b0);
    apre = 1'b0; arst = 1'b0;
    @(negedge clk);
    check("R6 hold after reset term", q, 1'b0);

    // R1 mid-run reset
    @(negedge clk); apre = 1'b1; @(negedge clk); apre = 1'b0;
    rst_ni = 1'b0; #1;
    check("R1 async clear", q, 1'b0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    check("R1 stays clear", q, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule